// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide, two-address programming port of an eight-line interrupt controller. It decodes an initialization sequence, shared-port mask writes and operation commands. It holds the mask, in-service, rotation-offset, vector-base and mode state. It serves status reads and poll reads. The line that should be serviced comes from an external priority resolver as a valid flag plus a line number. The pending-request vector comes from an external request latch. This block does not search the pending requests and does not latch them.

Software writes at address 0 to start initialization or to issue commands. Writes at address 1 carry the follow-up initialization words and, in normal operation, the mask. The processor acknowledges with a one-cycle `inta` strobe. The block answers the cycle after with a registered vector and tells the request latch which line was taken.

All strobes last one cycle. The port has no back-pressure: the block accepts every strobe in the cycle it is asserted. `vec_valid` is a one-cycle qualifier, and the receiver must take the vector in that cycle. Read data is captured on the read strobe and holds until the next read.

Top module: `ictl_cmd_if`

## Requirements
- R1: A write at address 0 with bit 4 set clears the mask, in-service, offset, vector base and all mode flags, and records bit 0 (mode word wanted) and bit 1 (single mode). The address-1 writes that follow are taken in this order: vector base, then a cascade word unless single mode is set, then a mode word if one was wanted, then normal mask writes.
- R2: The vector base is bits 7:3 of the base word. On `inta` the block outputs base OR line one cycle later with `vec_valid` high. When the resolver shows nothing pending, it uses line 7.
- R3: In the mode word, bit 4 sets the nested flag `sfnm_o` and bit 1 sets auto end-of-interrupt (`aeoi_o`).
- R4: In normal state, an address-1 write loads the mask. A read at address 1 returns the mask.
- R5: A write at address 0 with bit 4 = 0 and bit 3 = 1 is a status command. Bit 2 arms a poll. Bit 1 loads the read select from bit 0 (1 = in-service, 0 = pending requests). Bit 6 loads the special-mask flag from bit 5. A field whose enable bit is clear leaves its flag unchanged.
- R6: An acknowledge is `inta`, or a poll read, while the resolver shows a valid line. Outside auto-EOI it sets that line's in-service bit. One cycle later `ack_pulse` is high and `ack_line` carries the line.
- R7: In auto-EOI mode an acknowledge leaves the in-service register unchanged. If rotate-in-auto-EOI is set, the offset becomes line+1 mod 8. Command code 4 sets that flag and code 0 clears it. The command code is bits 7:5 of an address-0 write with bits 4:3 = 0.
- R8: Code 1 clears the in-service bit of highest priority. Priority starts at the line equal to the offset and goes upward, wrapping at 8. Code 5 does the same and also sets the offset to the cleared line+1. If no in-service bit is set, neither code changes anything.
- R9: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and also sets the offset to that line+1. Code 6 sets the offset to bits 2:0 plus 1, mod 8.
- R10: Code 2 changes neither the in-service register nor the offset.
- R11: A read while a poll is armed returns 0x80 OR the valid line and acknowledges it. If nothing is valid it returns 0. Either way the poll is disarmed, and the next read is a normal status read.
- R12: Read data appears the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| req_pend | input | LINES | Pending requests from the request latch |
| res_valid | input | 1 | Resolver has a line to service |
| res_line | input | LW | Line chosen by the resolver |
| inta | input | 1 | One-cycle acknowledge strobe |
| vec_out | output | 8 | Vector for the acknowledge |
| vec_valid | output | 1 | Vector qualifier, one cycle |
| ack_pulse | output | 1 | A line was acknowledged |
| ack_line | output | LW | Acknowledged line, to the latch |
| mask_o | output | LINES | Mask register |
| isr_o | output | LINES | In-service register |
| offset_o | output | LW | Priority rotation offset |
| smm_o | output | 1 | Special-mask flag |
| sfnm_o | output | 1 | Nested-mode flag |
| aeoi_o | output | 1 | Auto end-of-interrupt flag |

## Verification
The hardest case to reach is a non-specific end-of-interrupt after the offset has been rotated while two in-service bits sit on either side of the rotation point. That is the only case where the wrapped search gives a different answer from a plain lowest-index search. The stimulus sets the offset with code 6, then acknowledges lines 1 and 4 through the resolver inputs. It then issues code 1 and expects line 4, not line 1, to be cleared. Auto-EOI rotation needs its own path: the bench reinitializes with a mode word, and only then can an acknowledge move the offset without touching the in-service register.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } seq_st_e;

  // operation command codes, bits 7:5 of an address-0 command byte
  typedef enum logic [2:0] {
    OP_ROT_OFF = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_ON  = 3'd4,
    OP_REOI    = 3'd5,
    OP_SETPRI  = 3'd6,
    OP_RSEOI   = 3'd7
  } op_code_e;
endpackage

// File: rtl/ictl_seq.sv
module ictl_seq
  import ictl_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               addr,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               poll_clr,
  output logic               init_evt,
  output logic               in_normal,
  output logic [LINES-1:0]   mask_q,
  output logic [BYTE_W-1:LW] base_q,
  output logic               sfnm_q,
  output logic               aeoi_q,
  output logic               rsel_q,
  output logic               smm_q,
  output logic               poll_q
);
  seq_st_e state_q;
  logic    need4_q, single_q;
  logic    stat_wr, data_wr;

  assign init_evt  = wr && !addr && wdata[4];
  assign stat_wr   = wr && !addr && !wdata[4] && wdata[3];
  assign data_wr   = wr && addr;
  assign in_normal = (state_q == ST_NORM);

  always_ff @(posedge clk) begin
    if (!rst_n || init_evt) begin
      state_q  <= rst_n ? ST_BASE : ST_NORM;
      need4_q  <= rst_n ? wdata[0] : 1'b0;
      single_q <= rst_n ? wdata[1] : 1'b0;
      mask_q   <= '0;
      base_q   <= '0;
      sfnm_q   <= 1'b0;
      aeoi_q   <= 1'b0;
      rsel_q   <= 1'b0;
      smm_q    <= 1'b0;
      poll_q   <= 1'b0;
    end else begin
      if (stat_wr && wdata[2]) poll_q <= 1'b1;
      else if (poll_clr)       poll_q <= 1'b0;
      if (stat_wr && wdata[1]) rsel_q <= wdata[0];
      if (stat_wr && wdata[6]) smm_q  <= wdata[5];
      if (data_wr) begin
        unique case (state_q)
          ST_NORM: mask_q <= wdata[LINES-1:0];
          ST_BASE: begin
            base_q  <= wdata[BYTE_W-1:LW];
            state_q <= !single_q ? ST_CASC : (need4_q ? ST_MODE : ST_NORM);
          end
          ST_CASC: state_q <= need4_q ? ST_MODE : ST_NORM;
          ST_MODE: begin
            sfnm_q  <= wdata[4];
            aeoi_q  <= wdata[1];
            state_q <= ST_NORM;
          end
          default: state_q <= ST_NORM;
        endcase
      end
    end
  end
endmodule

// File: rtl/ictl_isr.sv
module ictl_isr
  import ictl_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_clr,
  input  logic              op_wr,
  input  logic [BYTE_W-1:0] op_byte,
  input  logic              ack,
  input  logic [LW-1:0]     ack_line,
  input  logic              aeoi,
  output logic [LINES-1:0]  isr_q,
  output logic [LW-1:0]     offset_q
);
  logic             rot_q, rot_d;
  logic [LINES-1:0] set_m, clr_m;
  logic [LW-1:0]    off_d, eoi_line, cmd_line;
  logic             eoi_hit;
  op_code_e         code;

  assign code     = op_code_e'(op_byte[7:5]);
  assign cmd_line = op_byte[LW-1:0];

  // wrapped search of the in-service bits, starting at the offset
  always_comb begin
    eoi_hit  = 1'b0;
    eoi_line = offset_q;
    for (int p = LINES - 1; p >= 0; p--) begin
      if (isr_q[offset_q + LW'(p)]) begin
        eoi_hit  = 1'b1;
        eoi_line = offset_q + LW'(p);
      end
    end
  end

  always_comb begin
    set_m = '0;
    clr_m = '0;
    off_d = offset_q;
    rot_d = rot_q;
    if (ack) begin
      if (!aeoi)      set_m[ack_line] = 1'b1;
      else if (rot_q) off_d = ack_line + LW'(1);
    end
    if (op_wr) begin
      unique case (code)
        OP_ROT_OFF, OP_ROT_ON: rot_d = code[2];
        OP_EOI, OP_REOI: begin
          if (eoi_hit) begin
            clr_m[eoi_line] = 1'b1;
            if (code == OP_REOI) off_d = eoi_line + LW'(1);
          end
        end
        OP_SEOI:   clr_m[cmd_line] = 1'b1;
        OP_SETPRI: off_d = cmd_line + LW'(1);
        OP_RSEOI: begin
          clr_m[cmd_line] = 1'b1;
          off_d = cmd_line + LW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init_clr) begin
      isr_q    <= '0;
      offset_q <= '0;
      rot_q    <= 1'b0;
    end else begin
      isr_q    <= (isr_q & ~clr_m) | set_m;
      offset_q <= off_d;
      rot_q    <= rot_d;
    end
  end
endmodule

// File: rtl/ictl_cmd_if.sv
module ictl_cmd_if
  import ictl_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [LINES-1:0]  req_pend,
  input  logic              res_valid,
  input  logic [LW-1:0]     res_line,
  input  logic              inta,
  output logic [7:0]        vec_out,
  output logic              vec_valid,
  output logic              ack_pulse,
  output logic [LW-1:0]     ack_line,
  output logic [LINES-1:0]  mask_o,
  output logic [LINES-1:0]  isr_o,
  output logic [LW-1:0]     offset_o,
  output logic              smm_o,
  output logic              sfnm_o,
  output logic              aeoi_o
);
  logic               init_evt, in_normal, rsel_q, poll_q;
  logic [BYTE_W-1:LW] base_q;
  logic               poll_rd, ack_now, op_wr;

  assign poll_rd = bus_rd && poll_q;
  assign ack_now = (inta || poll_rd) && res_valid;
  assign op_wr   = bus_wr && !bus_addr && !bus_wdata[4] && !bus_wdata[3];

  ictl_seq #(.LINES(LINES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .poll_clr(poll_rd), .init_evt(init_evt), .in_normal(in_normal),
    .mask_q(mask_o), .base_q(base_q), .sfnm_q(sfnm_o), .aeoi_q(aeoi_o),
    .rsel_q(rsel_q), .smm_q(smm_o), .poll_q(poll_q)
  );

  ictl_isr #(.LINES(LINES)) u_isr (
    .clk(clk), .rst_n(rst_n), .init_clr(init_evt), .op_wr(op_wr),
    .op_byte(bus_wdata), .ack(ack_now), .ack_line(res_line), .aeoi(aeoi_o),
    .isr_q(isr_o), .offset_q(offset_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      ack_pulse <= 1'b0;
      ack_line  <= '0;
    end else begin
      vec_valid <= inta;
      ack_pulse <= ack_now;
      if (ack_now) ack_line <= res_line;
      if (inta) vec_out <= {base_q, (res_valid ? res_line : {LW{1'b1}})};
      if (bus_rd) begin
        if (poll_q)        bus_rdata <= res_valid ? {1'b1, (BYTE_W-1-LW)'(0), res_line} : '0;
        else if (bus_addr) bus_rdata <= BYTE_W'(mask_o);
        else if (rsel_q)   bus_rdata <= BYTE_W'(isr_o);
        else               bus_rdata <= BYTE_W'(req_pend);
      end
    end
  end
endmodule

// File: rtl/ictl_cmd_if_chk.sv
module ictl_cmd_if_chk #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             res_valid,
  input logic [LW-1:0]    res_line,
  input logic             inta,
  input logic [7:0]       vec_out,
  input logic             vec_valid,
  input logic             ack_pulse,
  input logic [LW-1:0]    ack_line,
  input logic [LINES-1:0] mask_o,
  input logic [LINES-1:0] isr_o,
  input logic [LW-1:0]    offset_o,
  input logic             aeoi_o,
  input logic             in_normal
);
  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && bus_wdata[4] |=> mask_o == '0 && isr_o == '0 && offset_o == '0);
  // R2
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta && !res_valid |=> vec_valid && vec_out[LW-1:0] == {LW{1'b1}});
  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_normal && bus_wr && bus_addr |=> mask_o == $past(bus_wdata[LINES-1:0]));
  // R6
  ack_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta && res_valid |=> ack_pulse && ack_line == $past(res_line));
  // R7
  aeoi_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta && res_valid && aeoi_o && !bus_wr |=> $stable(isr_o));
  // R9
  spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && bus_wdata[7:3] == 5'b01100 && !inta && !bus_rd
      |=> !isr_o[$past(bus_wdata[LW-1:0])]);
  // R10
  nop_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && bus_wdata[7:3] == 5'b01000 && !inta && !bus_rd
      |=> $stable(isr_o) && $stable(offset_o));
endmodule

bind ictl_cmd_if ictl_cmd_if_chk #(.LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .res_valid(res_valid), .res_line(res_line), .inta(inta),
  .vec_out(vec_out), .vec_valid(vec_valid), .ack_pulse(ack_pulse), .ack_line(ack_line),
  .mask_o(mask_o), .isr_o(isr_o), .offset_o(offset_o), .aeoi_o(aeoi_o),
  .in_normal(in_normal)
);

// File: tb/ictl_cmd_if_tb_top.sv
module ictl_cmd_if_tb_top;
  localparam int LINES = 8;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, inta = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [LINES-1:0] req_pend = '0;
  logic res_valid = 1'b0;
  logic [LW-1:0] res_line = '0;
  logic [7:0] bus_rdata, vec_out;
  logic vec_valid, ack_pulse, smm_o, sfnm_o, aeoi_o;
  logic [LW-1:0] ack_line, offset_o;
  logic [LINES-1:0] mask_o, isr_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_vec;
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  ictl_cmd_if #(.LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_pend(req_pend),
    .res_valid(res_valid), .res_line(res_line), .inta(inta), .vec_out(vec_out),
    .vec_valid(vec_valid), .ack_pulse(ack_pulse), .ack_line(ack_line),
    .mask_o(mask_o), .isr_o(isr_o), .offset_o(offset_o), .smm_o(smm_o),
    .sfnm_o(sfnm_o), .aeoi_o(aeoi_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic a, input logic [7:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    it.is_vec = 1'b0; it.val = e; it.tag = tag;
    exp_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ack_exp(input logic [7:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    it.is_vec = 1'b1; it.val = e; it.tag = tag;
    exp_q.push_back(it);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic set_res(input logic v, input logic [LW-1:0] l);
    res_valid = v; res_line = l;
  endtask

  // monitor: compares each registered result against the scoreboard
  always @(posedge clk) begin
    if (bus_rd || inta) begin
      bit was_vec;
      exp_t it;
      was_vec = inta;
      #2;
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL scoreboard: actual unexpected result expected none");
      end else begin
        it = exp_q.pop_front();
        if (was_vec) begin
          chk({it.tag, " vec_valid"}, {7'd0, vec_valid}, 8'd1);
          chk(it.tag, vec_out, it.val);
        end else begin
          chk(it.tag, bus_rdata, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R1 mask", mask_o, 8'h00);
    chk("reset R1 isr", isr_o, 8'h00);
    chk("reset R1 offset", 8'(offset_o), 8'h00);
    chk("reset R12 rdata", bus_rdata, 8'h00);
    chk("reset R2 vec_valid", {7'd0, vec_valid}, 8'h00);

    // R1 full sequence with cascade and mode word; R3 mode word zeros
    wr(0, 8'h11); wr(1, 8'h23); wr(1, 8'h04); wr(1, 8'h01);
    chk("R3 sfnm off", {7'd0, sfnm_o}, 8'h00);
    chk("R3 aeoi off", {7'd0, aeoi_o}, 8'h00);
    wr(1, 8'hA5);
    chk("R4 mask load", mask_o, 8'hA5);
    rd_exp(1, 8'hA5, "R4 mask read");
    @(negedge clk);
    chk("R12 rdata holds", bus_rdata, 8'hA5);

    // R6 acknowledge, R2 vector
    set_res(1, 3);
    ack_exp(8'h23, "R2 vector line3");
    chk("R6 ack_pulse", {7'd0, ack_pulse}, 8'h01);
    chk("R6 ack_line", 8'(ack_line), 8'h03);
    chk("R6 isr set", isr_o, 8'h08);

    // R5 read select
    req_pend = 8'h5A;
    wr(0, 8'h0B); rd_exp(0, 8'h08, "R5 read isr");
    wr(0, 8'h0A); rd_exp(0, 8'h5A, "R5 read pending");

    // R8 non-specific and rotating EOI
    set_res(1, 5); ack_exp(8'h25, "R2 vector line5");
    chk("R6 isr two", isr_o, 8'h28);
    wr(0, 8'h20);
    chk("R8 eoi clears line3", isr_o, 8'h20);
    wr(0, 8'hA0);
    chk("R8 reoi clears line5", isr_o, 8'h00);
    chk("R8 reoi offset", 8'(offset_o), 8'h06);

    // R9 set priority; R8 wrapped search
    wr(0, 8'hC2);
    chk("R9 setpri offset", 8'(offset_o), 8'h03);
    set_res(1, 1); ack_exp(8'h21, "R2 vector line1");
    set_res(1, 4); ack_exp(8'h24, "R2 vector line4");
    chk("R6 isr pair", isr_o, 8'h12);
    wr(0, 8'h20);
    chk("R8 wrapped eoi", isr_o, 8'h02);

    // R9 rotating specific and specific EOI
    wr(0, 8'hE1);
    chk("R9 rseoi isr", isr_o, 8'h00);
    chk("R9 rseoi offset", 8'(offset_o), 8'h02);
    set_res(1, 6); ack_exp(8'h26, "R2 vector line6");
    wr(0, 8'h66);
    chk("R9 seoi isr", isr_o, 8'h00);

    // R10 no-op code
    set_res(1, 0); ack_exp(8'h20, "R2 vector line0");
    wr(0, 8'h40);
    chk("R10 isr kept", isr_o, 8'h01);
    chk("R10 offset kept", 8'(offset_o), 8'h02);
    wr(0, 8'hA0);
    chk("R8 reoi line0 offset", 8'(offset_o), 8'h01);
    wr(0, 8'hA0);
    chk("R8 empty isr offset", 8'(offset_o), 8'h01);

    // R2 spurious
    set_res(0, 0); ack_exp(8'h27, "R2 spurious vector");
    chk("R6 no ack_pulse", {7'd0, ack_pulse}, 8'h00);
    chk("R2 isr untouched", isr_o, 8'h00);

    // R11 poll
    wr(0, 8'h0C); set_res(1, 6);
    rd_exp(0, 8'h86, "R11 poll hit");
    chk("R11 poll ack isr", isr_o, 8'h40);
    rd_exp(0, 8'h5A, "R11 poll disarmed");
    wr(0, 8'h0C); set_res(0, 0);
    rd_exp(1, 8'h00, "R11 poll empty");
    rd_exp(1, 8'hA5, "R11 after empty poll");

    // R5 special mask
    wr(0, 8'h68); chk("R5 smm set", {7'd0, smm_o}, 8'h01);
    wr(0, 8'h28); chk("R5 smm kept", {7'd0, smm_o}, 8'h01);
    wr(0, 8'h48); chk("R5 smm clear", {7'd0, smm_o}, 8'h00);

    // R1 single mode, no mode word
    wr(0, 8'h12);
    chk("R1 init mask", mask_o, 8'h00);
    chk("R1 init isr", isr_o, 8'h00);
    wr(1, 8'h4D); wr(1, 8'h0F);
    chk("R1 single skip", mask_o, 8'h0F);
    ack_exp(8'h4F, "R2 base 48 spurious");

    // R3 and R7 auto-EOI
    wr(0, 8'h13); wr(1, 8'h60); wr(1, 8'h12);
    chk("R3 sfnm on", {7'd0, sfnm_o}, 8'h01);
    chk("R3 aeoi on", {7'd0, aeoi_o}, 8'h01);
    wr(0, 8'h80);
    set_res(1, 4); ack_exp(8'h64, "R7 vector line4");
    chk("R7 aeoi isr", isr_o, 8'h00);
    chk("R7 rotate offset", 8'(offset_o), 8'h05);
    wr(0, 8'h00);
    set_res(1, 1); ack_exp(8'h61, "R7 vector line1");
    chk("R7 no rotate offset", 8'(offset_o), 8'h05);
    chk("R7 isr still clear", isr_o, 8'h00);

    // R1 cascade word without mode word
    wr(0, 8'h10); wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h33);
    chk("R1 cascade then normal", mask_o, 8'h33);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule